// File: doc/BRIEF.md
# Programmable Sum-of-Products Term Array

This block is the logic core of a small programmable logic fabric. Sixteen input signals enter it, and each signal is offered to the array in true and in complemented form. That gives 32 array lines. There are 64 product terms, and each term is an AND over whichever of the 32 lines have been connected to it. The connections are held in configuration flops, one 32-bit row per term. A word-addressed write port loads one row at a time. An erase strobe opens every connection in a single cycle.

The terms are grouped into eight output slices of eight terms each. Slice s owns the terms at addresses 8*s through 8*s+7. The first seven terms of a slice always drive that slice's OR sum. The eighth, or spare, term is routed by a mode input. It either joins the OR sum, or it is exported as the slice's output-enable term. Output macrocells and pin drivers sit outside this block and consume `sum_o` and `oe_o`. Those outputs are combinational functions of the stored rows and the current inputs.

Top module: `sop_array`

## Requirements
- R1: While `rst_ni` is low, and after it is released, every connection is open, so `sum_o` and `oe_o` read all ones whatever `sig_i` is.
- R2: A row written with `cfg_we_i` high at address `cfg_addr_i` takes effect only after the next rising clock edge; before that edge the outputs still reflect the old row.
- R3: Row bit 2k connects line `sig_i[k]` and row bit 2k+1 connects line `~sig_i[k]`; a bit value of 1 means connected, and a term is the AND of all its connected lines.
- R4: A term connected to both lines of one signal is false for every input, as is a term with all 32 bits set (the pattern for an unused term).
- R5: A term with no connections (row of all zeros) is true for every input.
- R6: `sum_o[s]` is the OR of terms 8s..8s+6, plus term 8s+7 when `spare_to_or_i` is 1.
- R7: When `spare_to_or_i` is 0, `oe_o[s]` equals term 8s+7, and that term has no effect on `sum_o[s]`.
- R8: When `spare_to_or_i` is 1, `oe_o` is all ones.
- R9: An erase strobe opens all 64 rows at the next clock edge.
- R10: If erase and write are both asserted in the same cycle, the erase wins and the addressed row is also left open.
- R11: A write changes only the addressed row; all other rows keep their contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock for the configuration store |
| rst_ni | input | 1 | Active-low asynchronous reset that opens all connections |
| sig_i | input | 16 | Array input signals |
| cfg_we_i | input | 1 | Row write strobe |
| cfg_addr_i | input | 6 | Product-term address of the row to write |
| cfg_row_i | input | 32 | Connection row; bit 2k is sig k true, bit 2k+1 is sig k complement |
| erase_i | input | 1 | Opens every connection at the next edge |
| spare_to_or_i | input | 1 | 1: spare term joins the OR sum; 0: it drives the output enable |
| sum_o | output | 8 | OR sum of each slice |
| oe_o | output | 8 | Output-enable term of each slice |

## Verification
Erase and row write are the two functions that can land on the same clock edge. The bench provokes this by raising both strobes in one cycle, with a row that would close every connection of its term. It then judges the result at the ports in the following cycle: every sum and every enable must read one. A surviving write would instead force that term false and pull its enable low. Separately, a write is sampled just before and just after its edge, in both spare-routing modes, against a bench model of the connection rows.

// File: rtl/sop_pkg.sv
package sop_pkg;
  localparam int unsigned SOP_SIGS   = 16;
  localparam int unsigned SOP_SLICES = 8;
  localparam int unsigned SOP_TPS    = 8;  // terms per slice, last is spare
endpackage

// File: rtl/sop_cfg_store.sv
module sop_cfg_store #(
  parameter int unsigned LINES = 32,
  parameter int unsigned TERMS = 64,
  localparam int unsigned AW   = $clog2(TERMS)
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         we_i,
  input  logic [AW-1:0]                addr_i,
  input  logic [LINES-1:0]             row_i,
  input  logic                         erase_i,
  output logic [TERMS-1:0][LINES-1:0]  rows_o
);
  for (genvar t = 0; t < TERMS; t++) begin : g_row
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                rows_o[t] <= '0;
      else if (erase_i)                           rows_o[t] <= '0;  // erase beats write
      else if (we_i && (addr_i == AW'(t)))        rows_o[t] <= row_i;
    end
  end
endmodule

// File: rtl/sop_term_eval.sv
module sop_term_eval #(
  parameter int unsigned SIGS  = 16,
  parameter int unsigned TERMS = 64,
  localparam int unsigned LINES = 2 * SIGS
) (
  input  logic [SIGS-1:0]              sig_i,
  input  logic [TERMS-1:0][LINES-1:0]  rows_i,
  output logic [TERMS-1:0]             term_o
);
  logic [LINES-1:0] lines;

  for (genvar k = 0; k < SIGS; k++) begin : g_line
    assign lines[2*k]   = sig_i[k];
    assign lines[2*k+1] = ~sig_i[k];
  end

  // open connection -> don't care; true+complement -> always false
  for (genvar t = 0; t < TERMS; t++) begin : g_term
    assign term_o[t] = &(~rows_i[t] | lines);
  end
endmodule

// File: rtl/sop_slice.sv
module sop_slice #(
  parameter int unsigned TPS = 8
) (
  input  logic [TPS-1:0] terms_i,
  input  logic           spare_to_or_i,
  output logic           sum_o,
  output logic           oe_o
);
  logic main_or;
  logic spare;

  assign main_or = |terms_i[TPS-2:0];
  assign spare   = terms_i[TPS-1];
  assign sum_o   = main_or | (spare_to_or_i & spare);
  assign oe_o    = spare_to_or_i | spare;
endmodule

// File: rtl/sop_array.sv
module sop_array
  import sop_pkg::*;
#(
  parameter int unsigned SIGS   = SOP_SIGS,
  parameter int unsigned SLICES = SOP_SLICES,
  parameter int unsigned TPS    = SOP_TPS,
  localparam int unsigned LINES = 2 * SIGS,
  localparam int unsigned TERMS = SLICES * TPS,
  localparam int unsigned AW    = $clog2(TERMS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [SIGS-1:0]   sig_i,
  input  logic              cfg_we_i,
  input  logic [AW-1:0]     cfg_addr_i,
  input  logic [LINES-1:0]  cfg_row_i,
  input  logic              erase_i,
  input  logic              spare_to_or_i,
  output logic [SLICES-1:0] sum_o,
  output logic [SLICES-1:0] oe_o
);
  logic [TERMS-1:0][LINES-1:0] rows;
  logic [TERMS-1:0]            terms;

  sop_cfg_store #(.LINES(LINES), .TERMS(TERMS)) i_store (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (cfg_we_i),
    .addr_i  (cfg_addr_i),
    .row_i   (cfg_row_i),
    .erase_i (erase_i),
    .rows_o  (rows)
  );

  sop_term_eval #(.SIGS(SIGS), .TERMS(TERMS)) i_eval (
    .sig_i  (sig_i),
    .rows_i (rows),
    .term_o (terms)
  );

  for (genvar s = 0; s < SLICES; s++) begin : g_slice
    sop_slice #(.TPS(TPS)) i_slice (
      .terms_i       (terms[s*TPS +: TPS]),
      .spare_to_or_i (spare_to_or_i),
      .sum_o         (sum_o[s]),
      .oe_o          (oe_o[s])
    );
  end
endmodule

// File: rtl/sop_array_chk.sv
module sop_array_chk #(
  parameter int unsigned SIGS   = 16,
  parameter int unsigned SLICES = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [SIGS-1:0]   sig_i,
  input logic              cfg_we_i,
  input logic              erase_i,
  input logic              spare_to_or_i,
  input logic [SLICES-1:0] sum_o,
  input logic [SLICES-1:0] oe_o
);
  p_erase_open_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    erase_i |=> (sum_o == '1));

  p_erase_wins_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (erase_i && cfg_we_i) |=> (oe_o == '1 || spare_to_or_i));

  p_oe_forced_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    spare_to_or_i |-> (oe_o == '1));

  p_cfg_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$past(cfg_we_i) && !$past(erase_i) && $stable(sig_i) && $stable(spare_to_or_i))
      |-> ($stable(sum_o) && $stable(oe_o)));
endmodule

bind sop_array sop_array_chk #(.SIGS(SIGS), .SLICES(SLICES)) i_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .sig_i         (sig_i),
  .cfg_we_i      (cfg_we_i),
  .erase_i       (erase_i),
  .spare_to_or_i (spare_to_or_i),
  .sum_o         (sum_o),
  .oe_o          (oe_o)
);

// File: tb/test_sop_array.sv
module test_sop_array;
  localparam int CLK_PERIOD = 10;
  localparam int NS = 16;
  localparam int NSL = 8;
  localparam int TPS = 8;
  localparam int NT = NSL * TPS;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic [NS-1:0] sig_i = '0;
  logic          cfg_we_i = 1'b0;
  logic [5:0]    cfg_addr_i = '0;
  logic [31:0]   cfg_row_i = '0;
  logic          erase_i = 1'b0;
  logic          spare_to_or_i = 1'b0;
  logic [NSL-1:0] sum_o, oe_o;

  int n_tests = 0;
  int n_fail = 0;
  bit done = 0;
  logic [31:0] mrow [NT];

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  sop_array i_sop_array (
    .clk_i(clk_i), .rst_ni(rst_ni), .sig_i(sig_i), .cfg_we_i(cfg_we_i),
    .cfg_addr_i(cfg_addr_i), .cfg_row_i(cfg_row_i), .erase_i(erase_i),
    .spare_to_or_i(spare_to_or_i), .sum_o(sum_o), .oe_o(oe_o)
  );

  function automatic bit term_val(logic [31:0] row, logic [NS-1:0] s);
    for (int k = 0; k < NS; k++) begin
      if (row[2*k] && !s[k]) return 1'b0;
      if (row[2*k+1] && s[k]) return 1'b0;
    end
    return 1'b1;
  endfunction

  function automatic logic [15:0] model(logic [NS-1:0] s, bit mode);
    logic [NSL-1:0] su, oe;
    for (int sl = 0; sl < NSL; sl++) begin
      bit acc = 0;
      bit sp;
      for (int t = 0; t < TPS-1; t++) acc |= term_val(mrow[sl*TPS+t], s);
      sp = term_val(mrow[sl*TPS+TPS-1], s);
      su[sl] = acc | (mode & sp);
      oe[sl] = mode ? 1'b1 : sp;
    end
    return {su, oe};
  endfunction

  task automatic chk(string req, logic [15:0] got, logic [15:0] exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s sig=%h mode=%0b got sum/oe=%h expected %h",
               req, sig_i, spare_to_or_i, got, exp);
    end
  endtask

  task automatic chk_model(string req);
    #1 chk(req, {sum_o, oe_o}, model(sig_i, spare_to_or_i));
  endtask

  task automatic wr(int a, logic [31:0] r);
    @(negedge clk_i);
    cfg_we_i = 1; cfg_addr_i = 6'(a); cfg_row_i = r;
    @(negedge clk_i);
    cfg_we_i = 0;
    mrow[a] = r;
  endtask

  function automatic logic [31:0] pat(int t, int v);
    if (t % 9 == v) return '0;                          // open term (R5)
    if (t % 11 == 5) return 32'h3 << (2 * ((t + v) % NS)); // contradiction (R4)
    return (32'h1 << ((t * 7 + v * 3) % 32)) | (32'h1 << ((t * 13 + v) % 32));
  endfunction

  task automatic sweep(string req, int n, int seed);
    for (int i = 0; i < n; i++) begin
      @(negedge clk_i);
      sig_i = NS'((i * 40503 + seed) ^ (i << 7));
      spare_to_or_i = i[0];
      chk_model(req);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    for (int t = 0; t < NT; t++) mrow[t] = '0;
    #2;
    // R1: during reset all open
    sig_i = 16'hA5C3;
    #1 chk("R1 in reset", {sum_o, oe_o}, 16'hFFFF);
    repeat (2) @(negedge clk_i);
    rst_ni = 1;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk_i);
      sig_i = NS'(i * 16'h3B17);
      spare_to_or_i = i[0];
      #1 chk("R1 after reset", {sum_o, oe_o}, 16'hFFFF);
    end

    // R4: every term closed on all lines -> all false
    for (int t = 0; t < NT; t++) wr(t, '1);
    @(negedge clk_i); spare_to_or_i = 0; sig_i = 16'h1234;
    #1 chk("R4 all closed mode0", {sum_o, oe_o}, 16'h0000);
    @(negedge clk_i); spare_to_or_i = 1;
    #1 chk("R8 all closed mode1", {sum_o, oe_o}, 16'h00FF);

    // R3/R5/R6/R7/R8/R11: patterned rows, swept inputs, both modes
    for (int v = 0; v < 3; v++) begin
      for (int t = 0; t < NT; t++) wr(t, pat(t, v));
      sweep("R3 R6 R7 R8", 300, v * 977);
    end

    // R7: only spare open -> oe high, sum untouched in mode0
    for (int t = 0; t < NT; t++) wr(t, '1);
    wr(3 * TPS + TPS - 1, '0);
    @(negedge clk_i); spare_to_or_i = 0;
    #1 chk("R7 spare only mode0", {sum_o, oe_o}, 16'h0008);
    @(negedge clk_i); spare_to_or_i = 1;
    #1 chk("R6 spare only mode1", {sum_o, oe_o}, 16'h08FF);

    // R11: write one row, others unchanged
    wr(5 * TPS + 2, 32'h1);  // true when sig[0]=1
    @(negedge clk_i); spare_to_or_i = 0; sig_i = 16'h0001;
    #1 chk("R11 single row", {sum_o, oe_o}, 16'h2008);
    sig_i = 16'h0000;
    #1 chk("R3 single row off", {sum_o, oe_o}, 16'h0008);

    // R2: before edge old, after edge new
    @(negedge clk_i);
    sig_i = 16'h0000;
    cfg_we_i = 1; cfg_addr_i = 6'(0); cfg_row_i = 32'h2; // sig[0] complement
    #1 chk("R2 before edge", {sum_o, oe_o}, 16'h0008);
    @(negedge clk_i);
    cfg_we_i = 0; mrow[0] = 32'h2;
    #1 chk("R2 after edge", {sum_o, oe_o}, 16'h0108);

    // R9: erase
    @(negedge clk_i); erase_i = 1;
    @(negedge clk_i); erase_i = 0;
    for (int t = 0; t < NT; t++) mrow[t] = '0;
    #1 chk("R9 erase", {sum_o, oe_o}, 16'hFFFF);

    // R10: erase and write together
    for (int t = 0; t < NT; t++) wr(t, '1);
    @(negedge clk_i);
    erase_i = 1; cfg_we_i = 1; cfg_addr_i = 6'(TPS - 1); cfg_row_i = '1;
    @(negedge clk_i);
    erase_i = 0; cfg_we_i = 0;
    for (int t = 0; t < NT; t++) mrow[t] = '0;
    #1 chk("R10 erase wins", {sum_o, oe_o}, 16'hFFFF);
    sweep("R5 open after erase", 20, 11);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule